// File: doc/BRIEF.md
# Tagged Register Scoreboard

This block keeps the register values of an in-order issue machine whose results may come back out of order. Every register entry holds its data, a ready flag and the tag of the youngest instruction that will write it. When decode accepts an instruction, a tag is drawn from a wrapping counter and returned to the caller. That tag is written into the entry of the destination register, and the entry's ready flag is cleared. A source register whose flag is clear makes decode stall. While a stall holds, no tag is drawn.

Results come back on two writeback ports. Each port carries a tag, a register index and a data word. A result is accepted only when its tag equals the producer tag stored for that register. A result from an older, overtaken producer is therefore dropped, and a later reader cannot pick up a stale value. A result accepted in a cycle is already visible to the source reads of that same cycle. The two source operand values and their ready flags are outputs, so the caller reads operands from this block directly.

Top module: `regtag_scoreboard`

## Requirements
- R1: After reset every register reads as ready with data zero, the tag output is zero and no stall is raised.
- R2: The tag output shows the next free tag. Each accepted decode (`dec_valid` high, `dec_stall` low) advances it by one, wrapping modulo 2^TAG_W. A stalled decode leaves it unchanged.
- R3: An accepted decode stores its tag as the producer of its destination register and clears that register's ready flag from the next cycle on.
- R4: `dec_stall` is high exactly when `dec_valid` is high and at least one of the two sources is not ready. It is low whenever `dec_valid` is low.
- R5: A writeback whose tag equals the stored producer tag of its register writes the data and sets the ready flag from the next cycle on.
- R6: A writeback whose tag differs from the stored producer tag has no effect: the register keeps its data and its ready flag.
- R7: A source read in the same cycle as an accepted writeback to that register reports ready and returns the writeback data. Port 1 takes priority over port 0 if both match.
- R8: If decode retags a register in the same cycle that a writeback matching the old tag arrives, the decode wins: the register stays not ready under the new tag until a writeback carrying the new tag arrives.
- R9: The two writeback ports are checked independently, so both can complete different registers in one cycle.
- R10: When two in-flight producers of one register complete out of order, the younger result is kept and the older result that arrives later is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | An instruction is presented at decode |
| dec_src_a | input | IDX_W | First source register index |
| dec_src_b | input | IDX_W | Second source register index |
| dec_dst | input | IDX_W | Destination register index |
| dec_stall | output | 1 | Decode must hold the instruction |
| dec_tag | output | TAG_W | Tag assigned to the presented instruction |
| src_a_rdy | output | 1 | First source value is available |
| src_a_data | output | DATA_W | First source value |
| src_b_rdy | output | 1 | Second source value is available |
| src_b_data | output | DATA_W | Second source value |
| wb0_en | input | 1 | Writeback port 0 carries a result |
| wb0_tag | input | TAG_W | Tag of the port 0 result |
| wb0_idx | input | IDX_W | Register index of the port 0 result |
| wb0_data | input | DATA_W | Port 0 result data |
| wb1_en | input | 1 | Writeback port 1 carries a result |
| wb1_tag | input | TAG_W | Tag of the port 1 result |
| wb1_idx | input | IDX_W | Register index of the port 1 result |
| wb1_data | input | DATA_W | Port 1 result data |

## Verification
The bench walks every register through the full cycle of retag, stall, writeback and ready, with a reference model of the entry state. It targets these cases:
- Same-cycle bypass: a design without it would stall one cycle too long or return old data.
- Older result arriving after a younger one: a design that ignores tags would overwrite the newer value.
- Stale result while the register is still pending: a design that ignores tags would mark the register ready too early.
- Retag colliding with an old result in one cycle: the register would wrongly turn ready.
- Tag wrap and a stalled decode: a design with a free-running counter would skip tags.

// File: rtl/rtsb_pkg.sv
package rtsb_pkg;

    // number of writeback ports feeding the register entries
    localparam int NUM_WB = 2;

    // what one register entry does on a clock edge
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_RETAG = 2'd1,
        UPD_FILL  = 2'd2
    } upd_e;

    // a retag from decode outranks a writeback in the same cycle
    function automatic upd_e pick_action(input logic retag, input logic filled);
        if (retag)
            return UPD_RETAG;
        else if (filled)
            return UPD_FILL;
        return UPD_HOLD;
    endfunction

endpackage

// File: rtl/rtsb_tag_ctr.sv
module rtsb_tag_ctr #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [TAG_W-1:0] tag
);
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst)
            tag_q <= '0;
        else if (adv)
            tag_q <= tag_q + 1'b1;
    end

    assign tag = tag_q;
endmodule

// File: rtl/rtsb_entry.sv
module rtsb_entry
    import rtsb_pkg::*;
#(
    parameter int IDX    = 0,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          retag,
    input  logic [TAG_W-1:0]              new_tag,
    input  logic [NUM_WB-1:0]             wb_en,
    input  logic [NUM_WB-1:0][TAG_W-1:0]  wb_tag,
    input  logic [NUM_WB-1:0][IDX_W-1:0]  wb_idx,
    input  logic [NUM_WB-1:0][DATA_W-1:0] wb_data,
    output logic                          valid,
    output logic [TAG_W-1:0]              tag,
    output logic [DATA_W-1:0]             data
);
    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              filled;
    logic [DATA_W-1:0] fill_data;
    upd_e              act;

    // each port is compared on its own; the later port wins the data mux
    always_comb begin
        filled    = 1'b0;
        fill_data = data_q;
        for (int k = 0; k < NUM_WB; k++) begin
            if (wb_en[k] && wb_idx[k] == IDX_W'(IDX) && wb_tag[k] == tag_q) begin
                filled    = 1'b1;
                fill_data = wb_data[k];
            end
        end
        act = pick_action(retag, filled);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b1;
            tag_q   <= '0;
            data_q  <= '0;
        end else begin
            case (act)
                UPD_RETAG: begin
                    tag_q   <= new_tag;
                    valid_q <= 1'b0;
                end
                UPD_FILL: begin
                    data_q  <= fill_data;
                    valid_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign valid = valid_q;
    assign tag   = tag_q;
    assign data  = data_q;
endmodule

// File: rtl/rtsb_operand.sv
module rtsb_operand
    import rtsb_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 16
) (
    input  logic [IDX_W-1:0]                src,
    input  logic [NUM_REGS-1:0]             valid_vec,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_arr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] data_arr,
    input  logic [NUM_WB-1:0]               wb_en,
    input  logic [NUM_WB-1:0][TAG_W-1:0]    wb_tag,
    input  logic [NUM_WB-1:0][IDX_W-1:0]    wb_idx,
    input  logic [NUM_WB-1:0][DATA_W-1:0]   wb_data,
    output logic                            rdy,
    output logic [DATA_W-1:0]               data
);
    logic hit;

    // write-before-read: an accepted result reaches the reader this cycle
    always_comb begin
        hit  = 1'b0;
        data = data_arr[src];
        for (int k = 0; k < NUM_WB; k++) begin
            if (wb_en[k] && wb_idx[k] == src && wb_tag[k] == tag_arr[src]) begin
                hit  = 1'b1;
                data = wb_data[k];
            end
        end
        rdy = valid_vec[src] | hit;
    end
endmodule

// File: rtl/regtag_scoreboard.sv
module regtag_scoreboard
    import rtsb_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [IDX_W-1:0]  dec_src_a,
    input  logic [IDX_W-1:0]  dec_src_b,
    input  logic [IDX_W-1:0]  dec_dst,
    output logic              dec_stall,
    output logic [TAG_W-1:0]  dec_tag,
    output logic              src_a_rdy,
    output logic [DATA_W-1:0] src_a_data,
    output logic              src_b_rdy,
    output logic [DATA_W-1:0] src_b_data,
    input  logic              wb0_en,
    input  logic [TAG_W-1:0]  wb0_tag,
    input  logic [IDX_W-1:0]  wb0_idx,
    input  logic [DATA_W-1:0] wb0_data,
    input  logic              wb1_en,
    input  logic [TAG_W-1:0]  wb1_tag,
    input  logic [IDX_W-1:0]  wb1_idx,
    input  logic [DATA_W-1:0] wb1_data
);
    localparam int NUM_SRC = 2;

    logic [NUM_WB-1:0]               wb_en;
    logic [NUM_WB-1:0][TAG_W-1:0]    wb_tag;
    logic [NUM_WB-1:0][IDX_W-1:0]    wb_idx;
    logic [NUM_WB-1:0][DATA_W-1:0]   wb_data;

    logic [NUM_REGS-1:0]             valid_vec;
    logic [NUM_REGS-1:0][TAG_W-1:0]  tag_arr;
    logic [NUM_REGS-1:0][DATA_W-1:0] data_arr;

    logic [NUM_SRC-1:0][IDX_W-1:0]   src_idx;
    logic [NUM_SRC-1:0]              src_rdy;
    logic [NUM_SRC-1:0][DATA_W-1:0]  src_data;

    logic accept;

    assign wb_en   = {wb1_en,   wb0_en};
    assign wb_tag  = {wb1_tag,  wb0_tag};
    assign wb_idx  = {wb1_idx,  wb0_idx};
    assign wb_data = {wb1_data, wb0_data};
    assign src_idx = {dec_src_b, dec_src_a};

    assign dec_stall = dec_valid & ~(&src_rdy);
    assign accept    = dec_valid & ~dec_stall;

    rtsb_tag_ctr #(.TAG_W(TAG_W)) u_tag_ctr (
        .clk (clk),
        .rst (rst),
        .adv (accept),
        .tag (dec_tag)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
        rtsb_entry #(
            .IDX    (r),
            .IDX_W  (IDX_W),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) u_entry (
            .clk     (clk),
            .rst     (rst),
            .retag   (accept && dec_dst == IDX_W'(r)),
            .new_tag (dec_tag),
            .wb_en   (wb_en),
            .wb_tag  (wb_tag),
            .wb_idx  (wb_idx),
            .wb_data (wb_data),
            .valid   (valid_vec[r]),
            .tag     (tag_arr[r]),
            .data    (data_arr[r])
        );
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rtsb_operand #(
            .NUM_REGS (NUM_REGS),
            .IDX_W    (IDX_W),
            .TAG_W    (TAG_W),
            .DATA_W   (DATA_W)
        ) u_operand (
            .src       (src_idx[s]),
            .valid_vec (valid_vec),
            .tag_arr   (tag_arr),
            .data_arr  (data_arr),
            .wb_en     (wb_en),
            .wb_tag    (wb_tag),
            .wb_idx    (wb_idx),
            .wb_data   (wb_data),
            .rdy       (src_rdy[s]),
            .data      (src_data[s])
        );
    end

    assign src_a_rdy  = src_rdy[0];
    assign src_a_data = src_data[0];
    assign src_b_rdy  = src_rdy[1];
    assign src_b_data = src_data[1];
endmodule

// File: rtl/rtsb_checker.sv
module rtsb_checker #(
    parameter int NUM_REGS = 8,
    parameter int TAG_W    = 4,
    parameter int IDX_W    = 3
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           dec_valid,
    input logic                           dec_stall,
    input logic [IDX_W-1:0]               dec_dst,
    input logic [TAG_W-1:0]               dec_tag,
    input logic                           wb0_en,
    input logic                           wb1_en,
    input logic [NUM_REGS-1:0]            valid_vec,
    input logic [NUM_REGS-1:0][TAG_W-1:0] tag_arr
);
    // R2: an accepted decode advances the tag by exactly one
    p_tag_adv_r2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_stall) |=> dec_tag == TAG_W'($past(dec_tag) + 1'b1));

    // R2: a stalled or absent decode draws no tag
    p_tag_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(dec_valid && !dec_stall) |=> $stable(dec_tag));

    // R3: the destination is pending under the tag just handed out
    p_retag_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_stall) |=>
            (!valid_vec[$past(dec_dst)] && tag_arr[$past(dec_dst)] == $past(dec_tag)));

    // R4: no stall without a presented instruction
    p_no_idle_stall_r4: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !dec_stall);

    // R5: a ready flag only turns on after a writeback was presented
    p_fill_needs_wb_r5: assert property (@(posedge clk) disable iff (rst)
        (|(valid_vec & ~$past(valid_vec))) |-> $past(wb0_en || wb1_en));
endmodule

bind regtag_scoreboard rtsb_checker #(
    .NUM_REGS (NUM_REGS),
    .TAG_W    (TAG_W),
    .IDX_W    (IDX_W)
) u_rtsb_checker (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .dec_stall (dec_stall),
    .dec_dst   (dec_dst),
    .dec_tag   (dec_tag),
    .wb0_en    (wb0_en),
    .wb1_en    (wb1_en),
    .valid_vec (valid_vec),
    .tag_arr   (tag_arr)
);

// File: tb/regtag_scoreboard_tb_top.sv
`timescale 1ns/1ps
module regtag_scoreboard_tb_top;
    localparam int NR = 8;
    localparam int TW = 4;
    localparam int DW = 16;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dec_valid = 1'b0;
    logic [IW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
    logic          dec_stall;
    logic [TW-1:0] dec_tag;
    logic          src_a_rdy, src_b_rdy;
    logic [DW-1:0] src_a_data, src_b_data;
    logic          wb0_en = 1'b0, wb1_en = 1'b0;
    logic [TW-1:0] wb0_tag = '0, wb1_tag = '0;
    logic [IW-1:0] wb0_idx = '0, wb1_idx = '0;
    logic [DW-1:0] wb0_data = '0, wb1_data = '0;

    always #10 clk = ~clk;

    regtag_scoreboard #(.NUM_REGS(NR), .TAG_W(TW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .dec_valid(dec_valid),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
        .dec_stall(dec_stall), .dec_tag(dec_tag),
        .src_a_rdy(src_a_rdy), .src_a_data(src_a_data),
        .src_b_rdy(src_b_rdy), .src_b_data(src_b_data),
        .wb0_en(wb0_en), .wb0_tag(wb0_tag), .wb0_idx(wb0_idx), .wb0_data(wb0_data),
        .wb1_en(wb1_en), .wb1_tag(wb1_tag), .wb1_idx(wb1_idx), .wb1_data(wb1_data)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // reference state derived from the requirements
    logic          m_valid [NR];
    logic [TW-1:0] m_tag   [NR];
    logic [DW-1:0] m_data  [NR];
    logic [TW-1:0] m_ctr;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic wb_hit(input logic en, input logic [TW-1:0] t,
                                    input logic [IW-1:0] i, input logic [IW-1:0] r);
        return en && i == r && t == m_tag[r];
    endfunction

    // one cycle: drive at the falling edge, check outputs, then let the edge commit
    task automatic step(input string req, input logic dv,
                        input logic [IW-1:0] sa, input logic [IW-1:0] sb, input logic [IW-1:0] dst,
                        input logic e0, input logic [TW-1:0] t0, input logic [IW-1:0] i0, input logic [DW-1:0] d0,
                        input logic e1, input logic [TW-1:0] t1, input logic [IW-1:0] i1, input logic [DW-1:0] d1);
        logic          ra, rb, stall_e, acc;
        logic [DW-1:0] da, db;
        @(negedge clk);
        dec_valid = dv; dec_src_a = sa; dec_src_b = sb; dec_dst = dst;
        wb0_en = e0; wb0_tag = t0; wb0_idx = i0; wb0_data = d0;
        wb1_en = e1; wb1_tag = t1; wb1_idx = i1; wb1_data = d1;
        #1;
        ra = m_valid[sa]; da = m_data[sa];
        if (wb_hit(e0, t0, i0, sa)) begin ra = 1'b1; da = d0; end
        if (wb_hit(e1, t1, i1, sa)) begin ra = 1'b1; da = d1; end
        rb = m_valid[sb]; db = m_data[sb];
        if (wb_hit(e0, t0, i0, sb)) begin rb = 1'b1; db = d0; end
        if (wb_hit(e1, t1, i1, sb)) begin rb = 1'b1; db = d1; end
        stall_e = dv && !(ra && rb);
        chk(req, "dec_stall", int'(dec_stall), int'(stall_e));
        chk(req, "dec_tag",   int'(dec_tag),   int'(m_ctr));
        chk(req, "src_a_rdy", int'(src_a_rdy), int'(ra));
        chk(req, "src_b_rdy", int'(src_b_rdy), int'(rb));
        if (ra) chk(req, "src_a_data", int'(src_a_data), int'(da));
        if (rb) chk(req, "src_b_data", int'(src_b_data), int'(db));
        acc = dv && !stall_e;
        @(posedge clk);
        for (int r = 0; r < NR; r++) begin
            logic h0, h1;
            h0 = wb_hit(e0, t0, i0, IW'(r));
            h1 = wb_hit(e1, t1, i1, IW'(r));
            if (acc && dst == IW'(r)) begin
                m_tag[r] = m_ctr; m_valid[r] = 1'b0;
            end else if (h1) begin
                m_data[r] = d1; m_valid[r] = 1'b1;
            end else if (h0) begin
                m_data[r] = d0; m_valid[r] = 1'b1;
            end
        end
        if (acc) m_ctr = m_ctr + 1'b1;
    endtask

    task automatic probe(input string req, input logic [IW-1:0] sa, input logic [IW-1:0] sb);
        step(req, 1'b0, sa, sb, '0, 1'b0, '0, '0, '0, 1'b0, '0, '0, '0);
    endtask

    task automatic decode(input string req, input logic [IW-1:0] sa, input logic [IW-1:0] sb,
                          input logic [IW-1:0] dst);
        step(req, 1'b1, sa, sb, dst, 1'b0, '0, '0, '0, 1'b0, '0, '0, '0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] ta, tb;
        for (int r = 0; r < NR; r++) begin
            m_valid[r] = 1'b1; m_tag[r] = '0; m_data[r] = '0;
        end
        m_ctr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every register
        for (int r = 0; r < NR; r += 2) probe("R1", IW'(r), IW'(r + 1));

        // sweep every register through retag, stall, bypass and fill
        for (int i = 0; i < NR; i++) begin
            logic [IW-1:0] s;
            logic [DW-1:0] v;
            s  = IW'((i + 1) % NR);
            v  = DW'(i * 16'h0111 + 5);
            ta = m_ctr;
            decode("R3", s, s, IW'(i));
            probe("R3", IW'(i), s);
            step("R4", 1'b1, IW'(i), s, IW'((i + 2) % NR), 1'b0, '0, '0, '0, 1'b0, '0, '0, '0);
            step("R4", 1'b1, s, IW'(i), IW'((i + 2) % NR), 1'b0, '0, '0, '0, 1'b0, '0, '0, '0);
            if (i % 2 == 0)
                step("R7", 1'b0, IW'(i), s, '0, 1'b1, ta, IW'(i), v, 1'b0, '0, '0, '0);
            else
                step("R7", 1'b0, s, IW'(i), '0, 1'b0, '0, '0, '0, 1'b1, ta, IW'(i), v);
            probe("R5", IW'(i), IW'(i));
        end

        // R10: younger result first, older one later is dropped
        ta = m_ctr; decode("R10", 0, 0, 3);
        tb = m_ctr; decode("R10", 0, 0, 3);
        step("R10", 1'b0, 3, 3, 0, 1'b0, '0, '0, '0, 1'b1, tb, 3, 16'hAAAA);
        step("R6", 1'b0, 3, 3, 0, 1'b1, ta, 3, 16'hBBBB, 1'b0, '0, '0, '0);
        probe("R10", 3, 3);

        // R6: stale result while the register is still pending
        ta = m_ctr; decode("R6", 0, 0, 4);
        tb = m_ctr; decode("R6", 0, 0, 4);
        step("R6", 1'b0, 4, 4, 0, 1'b1, ta, 4, 16'h1234, 1'b0, '0, '0, '0);
        probe("R6", 4, 4);
        step("R6", 1'b0, 4, 0, 0, 1'b0, '0, '0, '0, 1'b1, tb, 4, 16'h4321);
        probe("R6", 4, 0);

        // R8: retag and old-tag result in the same cycle
        ta = m_ctr; decode("R8", 0, 0, 5);
        tb = m_ctr;
        step("R8", 1'b1, 0, 0, 5, 1'b1, ta, 5, 16'h5555, 1'b0, '0, '0, '0);
        probe("R8", 5, 5);
        step("R8", 1'b0, 5, 5, 0, 1'b1, tb, 5, 16'h6666, 1'b0, '0, '0, '0);
        probe("R8", 5, 5);

        // R9: both ports complete different registers together
        ta = m_ctr; decode("R9", 0, 0, 1);
        tb = m_ctr; decode("R9", 0, 0, 2);
        step("R9", 1'b1, 1, 2, 6, 1'b1, ta, 1, 16'h0101, 1'b1, tb, 2, 16'h0202);
        probe("R9", 1, 2);
        probe("R9", 6, 6);

        // R2: tag wraps across many accepted decodes
        for (int n = 0; n < 20; n++) decode("R2", 0, 0, 7);
        step("R2", 1'b1, 7, 0, 0, 1'b0, '0, '0, '0, 1'b0, '0, '0, '0);
        step("R2", 1'b0, 7, 7, 0, 1'b1, TW'(m_ctr - 1'b1), 7, 16'h7777, 1'b0, '0, '0, '0);
        probe("R2", 7, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule